// File: doc/BRIEF.md
# I2C Prioritized Interrupt Vector Unit

This block collects the event flags raised by an I2C controller's protocol engine, gates them with an interrupt enable mask, and raises a single interrupt line while any enabled flag is pending. Software finds out which event to service by reading a vector register. That register holds a small fixed-priority code that names the most urgent enabled event. Reading the vector also retires the flag it named, so an interrupt handler can loop on vector reads until the register returns zero.

The protocol engine signals each event with a one-cycle pulse. Software reaches the unit through a plain register port. Through that port it can read and selectively clear the status flags, read and write the enable mask, and read the vector. Bus busy and receive-shift-register-full are shown in the status register as live levels. They take no part in the interrupt logic.

Top module: `i2c_irq_vector`

## Requirements
- R1: After synchronous reset, all seven event flags and all mask bits are 0, the vector reads 0 and `irq` is low.
- R2: An event pulse sets its flag, and the flag stays set until it is cleared. The event bit positions, used both in `evt_pulse` and in status bits 6..0, are: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: Register address 0 is status. Writing it clears every flag whose bit in `wdata[6:0]` is 1. A bit written as 0 leaves its flag unchanged.
- R4: Register address 1 is the enable mask. It uses the same bit positions as R2 in bits 6..0, reads back as written, and reads 0 in bits 15..7.
- R5: Register address 2 is the vector. It returns code i+1 for the lowest-numbered flag i that is both set and enabled, so the codes run 1 (arbitration lost) to 7 (addressed as slave). It returns 0 when no enabled flag is set. Address 3 reads 0.
- R6: A read of the vector (`rd_en` with address 2) clears only the flag whose code was returned. All other flags keep their state.
- R7: `irq` is high exactly when at least one flag is set together with its mask bit.
- R8: An event pulse in the same cycle as a clear of that flag, whether by status write or by vector read, leaves the flag set.
- R9: Status bit 12 shows `bus_busy` and status bit 11 shows `rx_shift_full`, both as live levels. Writes never change them, and they have no vector code.
- R10: A flag whose mask bit is 0 is still visible in status, but it does not affect the vector or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 status, 1 mask, 2 vector |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; the read side effect applies to the vector only |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational from the current state |
| evt_pulse | input | 7 | One-cycle event pulses, bit positions as in R2 |
| bus_busy | input | 1 | Live bus-busy level |
| rx_shift_full | input | 1 | Live receive-shift-full level |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences come first. One raises every event while the mask is clear, which separates flag capture from the gating done by the mask. Another drains all seven flags by repeated vector reads, which shows whether the priority order is right and whether each read clears only the flag it reported. Further directed cases pulse an event in the very cycle it is cleared, by write and by vector read, which exposes a clear-over-set priority mistake. Others toggle the two level inputs and write to their bit positions. A long run of seeded random events, status writes, mask writes and vector reads follows. It is compared against a bench model cycle by cycle, which catches mismatches in encoding or in the clear masks when many flags are pending at once.

// File: rtl/i2c_irqv_pkg.sv
package i2c_irqv_pkg;

    localparam int NUM_EVT = 7;
    localparam int CODE_W  = $clog2(NUM_EVT + 1);
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int RSF_BIT = 11;
    localparam int BB_BIT  = 12;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT = 2'd0,
        ADR_MASK = 2'd1,
        ADR_VEC  = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic wr_stat;
        logic wr_mask;
        logic rd_vec;
    } reg_op_t;

    // lowest set index wins; code is index plus one, 0 when nothing pending
    function automatic logic [CODE_W-1:0] prio_code(input logic [NUM_EVT-1:0] pend);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (pend[i]) c = CODE_W'(i + 1);
        end
        return c;
    endfunction

    function automatic logic [NUM_EVT-1:0] code_onehot(input logic [CODE_W-1:0] c);
        logic [NUM_EVT-1:0] oh;
        oh = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (c == CODE_W'(i + 1)) oh[i] = 1'b1;
        end
        return oh;
    endfunction

endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_pulse,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (set_pulse[i])
                flag_q[i] <= 1'b1;
            else if (clr_req[i])
                flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
    import i2c_irqv_pkg::*;
(
    input  logic [NUM_EVT-1:0] flag_q,
    input  logic [NUM_EVT-1:0] mask_q,
    output logic [CODE_W-1:0]  vec_code,
    output logic [NUM_EVT-1:0] vec_onehot,
    output logic               any_pend
);
    logic [NUM_EVT-1:0] pend;

    always_comb begin
        pend       = flag_q & mask_q;
        vec_code   = prio_code(pend);
        vec_onehot = code_onehot(vec_code);
        any_pend   = |pend;
    end
endmodule

// File: rtl/irqv_regfile.sv
module irqv_regfile
    import i2c_irqv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] flag_q,
    input  logic [CODE_W-1:0]  vec_code,
    input  logic [NUM_EVT-1:0] vec_onehot,
    input  logic               bus_busy,
    input  logic               rx_shift_full,
    output logic [NUM_EVT-1:0] mask_q,
    output logic [NUM_EVT-1:0] clr_req,
    output logic               rd_vec,
    output logic [DATA_W-1:0]  rdata
);
    reg_addr_e sel;
    reg_op_t   op;

    always_comb begin
        sel        = reg_addr_e'(addr);
        op.wr_stat = wr_en && (sel == ADR_STAT);
        op.wr_mask = wr_en && (sel == ADR_MASK);
        op.rd_vec  = rd_en && (sel == ADR_VEC);
        rd_vec     = op.rd_vec;
        clr_req    = (op.wr_stat ? wdata[NUM_EVT-1:0] : '0)
                   | (op.rd_vec  ? vec_onehot          : '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (op.wr_mask)
            mask_q <= wdata[NUM_EVT-1:0];
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            ADR_STAT: begin
                rdata[NUM_EVT-1:0] = flag_q;
                rdata[RSF_BIT]     = rx_shift_full;
                rdata[BB_BIT]      = bus_busy;
            end
            ADR_MASK: rdata[NUM_EVT-1:0] = mask_q;
            ADR_VEC:  rdata[CODE_W-1:0]  = vec_code;
            ADR_NONE: rdata = '0;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
    import i2c_irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic              bus_busy,
    input  logic              rx_shift_full,
    output logic              irq
);
    logic [NUM_EVT-1:0] flag_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] clr_req;
    logic [NUM_EVT-1:0] vec_onehot;
    logic [CODE_W-1:0]  vec_code;
    logic               any_pend;
    logic               rd_vec;

    irqv_flag_bank #(.N(NUM_EVT)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (evt_pulse),
        .clr_req   (clr_req),
        .flag_q    (flag_q)
    );

    irqv_prio_enc u_enc (
        .flag_q     (flag_q),
        .mask_q     (mask_q),
        .vec_code   (vec_code),
        .vec_onehot (vec_onehot),
        .any_pend   (any_pend)
    );

    irqv_regfile u_regs (
        .clk           (clk),
        .rst           (rst),
        .addr          (addr),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .wdata         (wdata),
        .flag_q        (flag_q),
        .vec_code      (vec_code),
        .vec_onehot    (vec_onehot),
        .bus_busy      (bus_busy),
        .rx_shift_full (rx_shift_full),
        .mask_q        (mask_q),
        .clr_req       (clr_req),
        .rd_vec        (rd_vec),
        .rdata         (rdata)
    );

    assign irq = any_pend;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import i2c_irqv_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic [NUM_EVT-1:0] flag_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic [CODE_W-1:0]  vec_code,
    input logic               rd_vec,
    input logic               irq
);
    logic [NUM_EVT-1:0] rep_oh;
    logic               stat_wr;

    always_comb begin
        rep_oh  = code_onehot(vec_code);
        stat_wr = wr_en && (addr == 2'd0);
    end

    // R7: interrupt line agrees with the vector being nonzero
    p_irq_vec_r7: assert property (@(posedge clk) disable iff (rst)
        irq == (vec_code != '0));

    // R2 / R8: a pulsed event is set on the next cycle, whatever clear came with it
    p_evt_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R6: vector read retires the reported flag when no event re-sets it
    p_vec_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && (vec_code != '0) && ((rep_oh & evt_pulse) == '0))
        |=> ((flag_q & $past(rep_oh)) == '0));

    // R10: the reported flag is both set and enabled
    p_mask_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (vec_code != '0) |-> ((rep_oh & flag_q & mask_q) == rep_oh));

    // R3: a flag written with 0 and not read out stays set
    p_w0_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && flag_q[0] && !wdata[0] && !rd_vec) |=> flag_q[0]);
endmodule

bind i2c_irq_vector irqv_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .evt_pulse (evt_pulse),
    .flag_q    (flag_q),
    .mask_q    (mask_q),
    .vec_code  (vec_code),
    .rd_vec    (rd_vec),
    .irq       (irq)
);

// File: tb/sim_i2c_irq_vector.sv
`timescale 1ns/1ps
module sim_i2c_irq_vector;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  addr;
    logic        wr_en, rd_en;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [6:0]  evt_pulse;
    logic        bus_busy, rx_shift_full;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [6:0] m_flags;
    logic [6:0] m_mask;

    always #4 clk = ~clk;

    i2c_irq_vector u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse),
        .bus_busy(bus_busy), .rx_shift_full(rx_shift_full), .irq(irq)
    );

    function automatic logic [2:0] exp_code(input logic [6:0] f, input logic [6:0] m);
        logic [2:0] c;
        c = 3'd0;
        for (int i = 6; i >= 0; i--) if (f[i] && m[i]) c = 3'(i + 1);
        return c;
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [1:0] a, input logic bb, input logic rsf);
        case (a)
            2'd0:    return {3'b000, bb, rsf, 4'b0000, m_flags};
            2'd1:    return {9'd0, m_mask};
            2'd2:    return {13'd0, exp_code(m_flags, m_mask)};
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic [1:0] a, input logic we, input logic re,
                         input logic [15:0] wd, input logic [6:0] ev,
                         input logic bb, input logic rsf, input string req);
        logic [15:0] e;
        logic [2:0]  c;
        logic [6:0]  nf;
        @(negedge clk);
        addr = a; wr_en = we; rd_en = re; wdata = wd; evt_pulse = ev;
        bus_busy = bb; rx_shift_full = rsf;
        #1;
        e = exp_rdata(a, bb, rsf);
        chk(rdata === e, req, rdata, e);
        chk(irq === ((m_flags & m_mask) != 0), "R7", {15'd0, irq}, {15'd0, ((m_flags & m_mask) != 0)});
        nf = m_flags;
        if (we && a == 2'd0) nf = nf & ~wd[6:0];
        if (re && a == 2'd2) begin
            c = exp_code(m_flags, m_mask);
            if (c != 0) nf[c - 1] = 1'b0;
        end
        nf = nf | ev;
        m_flags = nf;
        if (we && a == 2'd1) m_mask = wd[6:0];
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        addr = 0; wr_en = 0; rd_en = 0; wdata = 0; evt_pulse = 0;
        bus_busy = 0; rx_shift_full = 0;
        rst = 1'b1;
        m_flags = 0; m_mask = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cycle(2'd0, 0, 0, 0, 0, 0, 0, "R1");
        cycle(2'd1, 0, 0, 0, 0, 0, 0, "R1");
        cycle(2'd2, 0, 0, 0, 0, 0, 0, "R1");

        // R9: live levels, writes to their bits do nothing
        cycle(2'd0, 0, 0, 0, 0, 1, 0, "R9");
        cycle(2'd0, 1, 0, 16'h1800, 0, 0, 1, "R9");
        cycle(2'd0, 0, 0, 0, 0, 1, 1, "R9");

        // R2 / R10: all events with mask clear
        cycle(2'd0, 0, 0, 0, 7'h7F, 0, 0, "R2");
        cycle(2'd0, 0, 0, 0, 0, 0, 0, "R2");
        cycle(2'd2, 0, 1, 0, 0, 0, 0, "R10");

        // R4: mask write and readback
        cycle(2'd1, 1, 0, 16'hFFFF, 0, 0, 0, "R4");
        cycle(2'd1, 0, 0, 0, 0, 0, 0, "R4");

        // R5 / R6: drain by vector reads, codes 1..7 then 0
        for (int k = 0; k < 8; k++) cycle(2'd2, 0, 1, 0, 0, 0, 0, "R6");
        cycle(2'd0, 0, 0, 0, 0, 0, 0, "R6");

        // R3: write-one-clear, write-zero keeps
        cycle(2'd0, 0, 0, 0, 7'h24, 0, 0, "R3");
        cycle(2'd0, 1, 0, 16'h0004, 0, 0, 0, "R3");
        cycle(2'd0, 1, 0, 16'h0000, 0, 0, 0, "R3");
        cycle(2'd0, 0, 0, 0, 0, 0, 0, "R3");

        // R8: set wins over write clear and over vector-read clear
        cycle(2'd0, 1, 0, 16'h0020, 7'h20, 0, 0, "R8");
        cycle(2'd0, 0, 0, 0, 0, 0, 0, "R8");
        cycle(2'd2, 0, 1, 0, 7'h20, 0, 0, "R8");
        cycle(2'd0, 0, 0, 0, 0, 0, 0, "R8");
        cycle(2'd2, 0, 0, 0, 0, 0, 0, "R8");

        // R10: partial mask leaves vector on enabled flag only
        cycle(2'd1, 1, 0, 16'h0040, 7'h1F, 0, 0, "R10");
        cycle(2'd2, 0, 0, 0, 0, 0, 0, "R10");

        // R5: random mix
        for (int n = 0; n < 2000; n++) begin
            logic [1:0]  a;
            logic        we, re;
            logic [6:0]  ev;
            a  = 2'($urandom_range(0, 3));
            we = ($urandom_range(0, 3) == 0);
            re = ($urandom_range(0, 1) == 0);
            ev = ($urandom_range(0, 2) == 0) ? 7'($urandom) : 7'd0;
            cycle(a, we, re, 16'($urandom), ev, 1'($urandom), 1'($urandom),
                  (a == 2'd1) ? "R4" : (a == 2'd0) ? "R2" : "R5");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule